// File: doc/BRIEF.md
# Serial Flash Generic Command Shifter

This block drives a single-lane SPI flash device with an arbitrary short command and keeps the reply. Software fills a bank of six transmit byte registers, writes the length of the whole exchange as a bit count, and then sets a command bit. The engine pulls chip select low and sends the bank out most significant bit first, starting with the highest-indexed byte. While it sends, it shifts the slave's reply into a ten-byte receive bank. The command bit stays set for the whole exchange and drops by itself when the exchange ends, so software only has to poll it.

Bit positions past the end of the transmit bank go out as zero. Software zeroes the bank before it loads a new command, so dummy bytes and unused positions need no extra work. In the receive bank the newest byte sits at index 0, and older bytes sit at higher indices. A second command bit runs the same exchange as a status-register write, and its completion sets a sticky interrupt-status bit. Software uses this once at start-up to unlock the device. SCLK is the system clock divided by a fixed parameter.

Top module: `sfc_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, SCLK is low, the irq output is low, and the command, interrupt-status and receive registers all read zero.
- R2: The register map uses these addresses. Command is 0x00, bit count is 0x01, interrupt status is 0x02, transmit index i is 0x08+i, and receive index i is 0x10+i. Only command bits 2 (generic) and 5 (status write) are accepted. If a command write keeps neither bit, or the bit count is zero, no transfer starts and the command register reads zero.
- R3: MOSI sends bit 7 of transmit index 5 first. The bits follow MSB-first through descending indices down to index 0, and every bit after the bank is zero.
- R4: A transfer produces exactly as many SCLK rising edges as the bit count register holds.
- R5: The receive bank is cleared when a transfer starts. When it finishes, the N sampled bits sit right-aligned across the bank with the last bit at bit 0 of index 0, and index i holds bits 8i+7..8i.
- R6: SPI mode 0 applies. SCLK is low whenever chip select is high, MISO is sampled on the rising SCLK edge, and MOSI stays stable while SCLK is high.
- R7: Chip select falls 2*HALF_DIV system cycles before the first SCLK rise. It rises HALF_DIV cycles after the last SCLK fall.
- R8: The accepted command bits read back while the transfer runs. They clear in the same cycle that chip select rises.
- R9: A command write made while a transfer runs is ignored. It does not change the command register, does not start a second transfer, and does not set the interrupt.
- R10: When a status-write command (bit 5) completes, interrupt-status bit 5 and the irq output go high. Writing a 1 to bit 5 of the interrupt-status register clears them. A generic command does not set this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| irq | output | 1 | Interrupt request from the status-write completion bit |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench builds the block with HALF_DIV set to 3 and keeps the default bank sizes of six transmit and ten receive bytes. An odd, non-minimal half period separates the setup gap (six cycles) from the release gap (three cycles), so an off-by-one in either delay shows up. With the default sizes, a 56-bit count runs past the transmit bank into zero fill. An 80-bit count fills the receive bank exactly, and a 13-bit count leaves a partial byte at index 1.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CMD   = 5'h00;
    localparam logic [ADDR_W-1:0] A_COUNT = 5'h01;
    localparam logic [ADDR_W-1:0] A_IRQ   = 5'h02;
    localparam int                TX_BASE = 8;
    localparam int                RX_BASE = 16;

    localparam int CMD_GENERIC_BIT = 2;
    localparam int CMD_STATUS_BIT  = 5;
    localparam int IRQ_STATUS_BIT  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } sfc_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sfc_bus_t;

    function automatic logic [DATA_W-1:0] accepted_cmd(input logic [DATA_W-1:0] raw);
        logic [DATA_W-1:0] keep;
        keep = '0;
        keep[CMD_GENERIC_BIT] = 1'b1;
        keep[CMD_STATUS_BIT]  = 1'b1;
        return raw & keep;
    endfunction

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sfc_bus_t                bus,
    output logic [DATA_W-1:0]       rdata,
    input  logic                    xfer_done,
    input  logic [RX_BYTES*8-1:0]   rx_flat,
    output logic                    start,
    output logic [CNT_W-1:0]        count,
    output logic [TX_BYTES*8-1:0]   tx_flat,
    output logic [DATA_W-1:0]       cmd_q,
    output logic                    irq_q
);

    logic [7:0]        tx_bank [TX_BYTES];
    logic [DATA_W-1:0] cmd_masked;
    logic              wr_cmd;

    assign cmd_masked = accepted_cmd(bus.data);
    assign wr_cmd     = bus.wr && (bus.addr == A_CMD);
    assign start      = wr_cmd && (cmd_q == '0) && (cmd_masked != '0) && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            count <= '0;
            irq_q <= 1'b0;
        end else begin
            if (start)
                cmd_q <= cmd_masked;
            else if (xfer_done)
                cmd_q <= '0;

            if (bus.wr && (bus.addr == A_COUNT))
                count <= CNT_W'(bus.data);

            if (xfer_done && cmd_q[CMD_STATUS_BIT])
                irq_q <= 1'b1;
            else if (bus.wr && (bus.addr == A_IRQ) && bus.data[IRQ_STATUS_BIT])
                irq_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < TX_BYTES; i++) begin : g_tx
        always_ff @(posedge clk) begin
            if (rst)
                tx_bank[i] <= '0;
            else if (bus.wr && (bus.addr == ADDR_W'(TX_BASE + i)))
                tx_bank[i] <= bus.data;
        end
        assign tx_flat[8*i +: 8] = tx_bank[i];
    end

    always_comb begin
        rdata = '0;
        if (bus.addr == A_CMD)
            rdata = cmd_q;
        if (bus.addr == A_COUNT)
            rdata = DATA_W'(count);
        if (bus.addr == A_IRQ)
            rdata[IRQ_STATUS_BIT] = irq_q;
        for (int i = 0; i < TX_BYTES; i++)
            if (bus.addr == ADDR_W'(TX_BASE + i))
                rdata = tx_bank[i];
        for (int i = 0; i < RX_BYTES; i++)
            if (bus.addr == ADDR_W'(RX_BASE + i))
                rdata = rx_flat[8*i +: 8];
    end

endmodule

// File: rtl/sfc_shift_engine.sv
module sfc_shift_engine
    import sfc_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNT_W    = 8,
    parameter int HALF_DIV = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [CNT_W-1:0]        count,
    input  logic [TX_BYTES*8-1:0]   tx_flat,
    output logic                    done,
    output logic [RX_BYTES*8-1:0]   rx_flat,
    output logic                    sclk,
    output logic                    cs_n,
    output logic                    mosi,
    input  logic                    miso
);

    localparam int TX_W  = TX_BYTES * 8;
    localparam int RX_W  = RX_BYTES * 8;
    localparam int DIV_W = $clog2(2 * HALF_DIV + 1);
    localparam logic [DIV_W-1:0] SETUP_LAST = DIV_W'(2 * HALF_DIV - 1);
    localparam logic [DIV_W-1:0] HALF_LAST  = DIV_W'(HALF_DIV - 1);

    sfc_state_e       state;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] bits_left;
    logic [TX_W-1:0]  tx_sr;
    logic [RX_W-1:0]  rx_sr;

    assign done    = (state == ST_TAIL) && (div == HALF_LAST);
    assign mosi    = !cs_n && tx_sr[TX_W-1];
    assign rx_flat = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            div       <= '0;
            bits_left <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_SETUP;
                        div       <= '0;
                        bits_left <= count;
                        tx_sr     <= tx_flat;
                        rx_sr     <= '0;
                        cs_n      <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (div == SETUP_LAST) begin
                        div       <= '0;
                        sclk      <= 1'b1;
                        rx_sr     <= {rx_sr[RX_W-2:0], miso};
                        bits_left <= bits_left - 1'b1;
                        state     <= ST_HIGH;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (div == HALF_LAST) begin
                        div  <= '0;
                        sclk <= 1'b0;
                        if (bits_left == '0) begin
                            state <= ST_TAIL;
                        end else begin
                            state <= ST_LOW;
                            tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (div == HALF_LAST) begin
                        div       <= '0;
                        sclk      <= 1'b1;
                        rx_sr     <= {rx_sr[RX_W-2:0], miso};
                        bits_left <= bits_left - 1'b1;
                        state     <= ST_HIGH;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (div == HALF_LAST) begin
                        div   <= '0;
                        cs_n  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sfc_cmd_shifter.sv
module sfc_cmd_shifter
    import sfc_pkg::*;
#(
    parameter int TX_BYTES = 6,
    parameter int RX_BYTES = 10,
    parameter int CNT_W    = 8,
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    sfc_bus_t              bus;
    logic                  start;
    logic                  xfer_done;
    logic [CNT_W-1:0]      count;
    logic [TX_BYTES*8-1:0] tx_flat;
    logic [RX_BYTES*8-1:0] rx_flat;
    logic [DATA_W-1:0]     cmd_q;
    logic                  irq_q;

    assign bus = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign irq = irq_q;

    sfc_regs #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES),
        .CNT_W    (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .rdata     (bus_rdata),
        .xfer_done (xfer_done),
        .rx_flat   (rx_flat),
        .start     (start),
        .count     (count),
        .tx_flat   (tx_flat),
        .cmd_q     (cmd_q),
        .irq_q     (irq_q)
    );

    sfc_shift_engine #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES),
        .CNT_W    (CNT_W),
        .HALF_DIV (HALF_DIV)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .count   (count),
        .tx_flat (tx_flat),
        .done    (xfer_done),
        .rx_flat (rx_flat),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

endmodule

// File: rtl/sfc_cmd_checker.sv
module sfc_cmd_checker
    import sfc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              spi_mosi,
    input logic              irq,
    input logic [DATA_W-1:0] cmd_q
);

    p_sclk_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_mosi_stable_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_cs_released_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == '0) |-> spi_cs_n);

    p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        ((cmd_q != '0) && bus_wr && (bus_addr == A_CMD))
            |=> ((cmd_q == $past(cmd_q)) || (cmd_q == '0)));

    p_irq_from_status_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cmd_q[CMD_STATUS_BIT]));

endmodule

bind sfc_cmd_shifter sfc_cmd_checker u_checker (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .irq      (irq),
    .cmd_q    (cmd_q)
);

// File: tb/test_sfc_cmd_shifter.sv
module test_sfc_cmd_shifter;

    localparam int HALF = 3;
    localparam int NV   = 6;
    // row: {bit count, tx bank index5..index0, slave reply stream (MSB first)}
    localparam logic [135:0] VECS [NV] = '{
        {8'd8,  48'h9F0000000000, 80'hC2000000000000000000},
        {8'd32, 48'h031234560000, 80'h000000005A3C0000FFEE},
        {8'd48, 48'h0BA1B2C3D4E5, 80'h112233445566778899AA},
        {8'd56, 48'hEB0102030405, 80'hF0E1D2C3B4A596870000},
        {8'd80, 48'h5AFF00FF00A5, 80'h0123456789ABCDEF1357},
        {8'd13, 48'hB7C800000000, 80'hABCD0000000000000000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;

    logic [79:0] reply = '0;
    logic [79:0] mosi_cap = '0;
    int unsigned sidx = 0;
    int unsigned rises = 0;
    int unsigned cs_falls = 0;
    int unsigned c_csf = 0, c_rise1 = 0, c_fall_last = 0, c_csr = 0;

    always #5 clk = ~clk;

    sfc_cmd_shifter #(.HALF_DIV(HALF)) i_sfc_cmd_shifter (
        .clk, .rst, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq,
        .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso
    );

    // Mode-0 flash model: presents bits on chip-select fall and SCLK fall.
    assign spi_miso = (sidx < 80) ? reply[79 - sidx] : 1'b0;

    always @(negedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        sidx = 0; rises = 0; mosi_cap = '0; c_csf = cyc; cs_falls++;
    end
    always @(posedge spi_cs_n) c_csr = cyc;
    always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
        sidx++; c_fall_last = cyc;
    end
    always @(posedge spi_sclk) begin
        if (rises == 0) c_rise1 = cyc;
        rises++;
        mosi_cap = {mosi_cap[78:0], spi_mosi};
    end

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int n = 0; n < 2000; n++) begin
            rd(5'h00, v);
            if (v == 8'h00) break;
        end
    endtask

    task automatic read_rx(output logic [79:0] rx);
        logic [7:0] v;
        rx = '0;
        for (int i = 0; i < 10; i++) begin
            rd(5'(16 + i), v);
            rx[8*i +: 8] = v;
        end
    endtask

    task automatic load_tx(input logic [47:0] tx);
        for (int i = 0; i < 6; i++) wr(5'(8 + i), tx[8*i +: 8]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [79:0] rx;
        int          n;
        logic [47:0] tx;
        logic [79:0] exp_mosi, exp_rx;
        int unsigned falls0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 cs_n", 80'(spi_cs_n), 80'd1);
        check("R1 sclk", 80'(spi_sclk), 80'd0);
        check("R1 irq", 80'(irq), 80'd0);
        rd(5'h00, v); check("R1 cmd", 80'(v), 80'd0);
        rd(5'h02, v); check("R1 irq status", 80'(v), 80'd0);
        read_rx(rx);  check("R1 rx bank", rx, 80'd0);

        // Table walk: R3, R4, R5 (and R7, R8, R9 on selected rows)
        for (int k = 0; k < NV; k++) begin
            n     = int'(VECS[k][135:128]);
            tx    = VECS[k][127:80];
            reply = VECS[k][79:0];
            load_tx(tx);
            wr(5'h01, 8'(n));
            wr(5'h00, 8'h04);
            rd(5'h00, v); check("R8 cmd set while running", 80'(v), 80'h04);
            if (k == 1) begin
                wr(5'h00, 8'h20);       // R9: ignored while busy
                rd(5'h00, v); check("R9 busy write ignored", 80'(v), 80'h04);
            end
            wait_idle();
            check("R8 cs released when cmd clears", 80'(spi_cs_n), 80'd1);
            exp_mosi = {tx, 32'h0} >> (80 - n);
            exp_rx   = reply >> (80 - n);
            check("R4 sclk pulses", 80'(rises), 80'(n));
            check("R3 mosi stream", mosi_cap, exp_mosi);
            read_rx(rx);
            check("R5 rx bank", rx, exp_rx);
            check("R10 generic leaves irq low", 80'(irq), 80'd0);
            if (k == 0) begin
                check("R7 setup gap", 80'(c_rise1 - c_csf), 80'(2 * HALF));
                check("R7 release gap", 80'(c_csr - c_fall_last), 80'(HALF));
            end
            if (k == 1) begin
                repeat (40) @(negedge clk);
                check("R9 no second transfer", 80'(spi_cs_n), 80'd1);
                rd(5'h02, v); check("R9 irq not set", 80'(v), 80'd0);
            end
        end

        // R5: receive bank is cleared at the next start
        reply = 80'h0;
        load_tx(48'h050000000000);
        wr(5'h01, 8'd8);
        wr(5'h00, 8'h04);
        wait_idle();
        read_rx(rx); check("R5 rx cleared on start", rx, 80'h0);

        // R2: unsupported bits and zero count start nothing
        falls0 = cs_falls;
        wr(5'h00, 8'h13);
        rd(5'h00, v); check("R2 unsupported cmd bits", 80'(v), 80'd0);
        wr(5'h01, 8'd0);
        wr(5'h00, 8'h04);
        rd(5'h00, v); check("R2 zero count cmd", 80'(v), 80'd0);
        repeat (20) @(negedge clk);
        check("R2 no chip select", 80'(cs_falls - falls0), 80'd0);

        // R10: status write with 16-bit count, zero data byte
        load_tx(48'h010000000000);
        wr(5'h01, 8'd16);
        reply = 80'h0;
        wr(5'h00, 8'h24);
        rd(5'h00, v); check("R2 accepted bits read back", 80'(v), 80'h24);
        wait_idle();
        check("R3 status write stream", mosi_cap, 80'h0100);
        check("R10 irq output set", 80'(irq), 80'd1);
        rd(5'h02, v); check("R10 status bit 5", 80'(v), 80'h20);
        wr(5'h02, 8'h1F);
        rd(5'h02, v); check("R10 other bits do not clear", 80'(v), 80'h20);
        wr(5'h02, 8'h20);
        rd(5'h02, v); check("R10 acknowledge clears", 80'(v), 80'h00);
        check("R10 irq output cleared", 80'(irq), 80'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule